// File: doc/BRIEF.md
# Interrupt Request Controller with Set/Clear Writes

This block gathers six internal event sources into one interrupt line. Each source owns a request flag that a one-cycle event pulse raises, and a matching enable bit. Software reaches both registers through a simple synchronous write port and a combinational read port. A write does not overwrite a register. Bit 7 of the written byte chooses the action, and the low six bits act as a mask. With bit 7 at 1, each marked bit is set. With bit 7 at 0, each marked bit is cleared. Unmarked bits keep their value.

The unit ORs the pending, enabled requests into one combined status bit, which software can read from a status register. The same bit drives the interrupt pin. A configuration register can invert the pin's polarity. It also selects between push-pull drive and open-drain drive. The pad is modelled as a data signal plus an output-enable signal, and the out-of-reset settings leave the pin undriven.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset all request flags and enable bits are 0, the status read is 0 and the pin output-enable is 0 (high impedance).
- R2: A write to the request register (address 07h) with bit 7 = 1 sets every flag whose data bit (0..5) is 1 and leaves the others unchanged; writing 81h sets only bit 0.
- R3: A write to the request register with bit 7 = 0 clears every flag whose data bit (0..5) is 1 and leaves the others unchanged; writing 3Fh clears all six.
- R4: The enable register (address 06h) follows the same set/clear rule. Bits 6 and 7 of both registers read as 0, and bit 6 ignores writes. Writes to other addresses change neither register.
- R5: An event pulse on source i sets request flag i at the next clock edge and never changes an enable bit. Flag bits: 0 low-alert, 1 high-alert, 2 idle, 3 receive, 4 transmit, 5 timer.
- R6: An event pulse arriving in the same cycle as a software clear of the same flag wins, so the flag ends up set.
- R7: Bit 3 of the status register (address 03h) is the OR over bits 0..5 of (flag AND enable). Its other bits read 0.
- R8: The pin configuration register (address 0Dh) is written by plain overwrite. Bit 0 selects push-pull and bit 1 selects inversion. Bits 7..2 read 0, and the reset value is 02h.
- R9: In push-pull mode the output-enable is 1 and the pin data equals the status bit XOR the invert bit.
- R10: In open-drain mode the pin data is 0, and the output-enable is 1 exactly when the status bit XOR the invert bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled at the clock edge |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data (bit 7 selects set or clear for flag registers) |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| evt_pulse | input | 6 | Per-source event pulses |
| irq_o | output | 1 | Interrupt pin data |
| irq_oe | output | 1 | Interrupt pin output-enable |

## Verification
The hardest case to produce is a clear write landing in the same clock edge as an event pulse on the same bit, because the two arrive through unrelated inputs. The bench drives the masked clear and the event pulse together in a single write cycle, then reads the flag back. The four pin cases also need care, because each one needs the combined status at both levels. The stimulus moves the status by toggling one enable bit and checks every polarity and drive combination in each state.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   typedef struct packed {
      logic invert;
      logic push_pull;
   } pin_cfg_t;

   typedef enum logic {
      WR_CLEAR = 1'b0,
      WR_SET   = 1'b1
   } wr_action_e;

   function automatic logic pin_level(input logic status, input pin_cfg_t cfg);
      return status ^ cfg.invert;
   endfunction

endpackage

// File: rtl/irqc_setclr_bank.sv
module irqc_setclr_bank #(
   parameter int WIDTH     = 6,
   parameter bit HAS_EVENT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_hit,
   input  logic             wr_sel,
   input  logic [WIDTH-1:0] wr_mask,
   input  logic [WIDTH-1:0] evt,
   output logic [WIDTH-1:0] bits_q
);
   import irqc_pkg::*;

   wr_action_e action;
   assign action = wr_action_e'(wr_sel);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("irqc_setclr_bank: WIDTH must be at least 1");
      end
   endgenerate

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic evt_i;
      if (HAS_EVENT) begin : g_evt
         assign evt_i = evt[i];
      end else begin : g_noevt
         logic evt_unused;
         assign evt_unused = evt[i];
         assign evt_i = 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bits_q[i] <= 1'b0;
         end else if (evt_i) begin
            bits_q[i] <= 1'b1;
         end else if (wr_hit && wr_mask[i]) begin
            bits_q[i] <= (action == WR_SET);
         end
      end
   end

endmodule

// File: rtl/irqc_pin_ctrl.sv
module irqc_pin_ctrl #(
   parameter bit RST_INVERT    = 1'b1,
   parameter bit RST_PUSH_PULL = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_hit,
   input  logic                 wr_pp,
   input  logic                 wr_inv,
   input  logic                 status,
   output irqc_pkg::pin_cfg_t   cfg_q,
   output logic                 pin_o,
   output logic                 pin_oe
);
   import irqc_pkg::*;

   logic level;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q.invert    <= RST_INVERT;
         cfg_q.push_pull <= RST_PUSH_PULL;
      end else if (wr_hit) begin
         cfg_q.invert    <= wr_inv;
         cfg_q.push_pull <= wr_pp;
      end
   end

   assign level = pin_level(status, cfg_q);

   always_comb begin
      if (cfg_q.push_pull) begin
         pin_o  = level;
         pin_oe = 1'b1;
      end else begin
         pin_o  = 1'b0;
         pin_oe = ~level;
      end
   end

endmodule

// File: rtl/irqc_read_mux.sv
module irqc_read_mux #(
   parameter int                ADDR_W    = 8,
   parameter int                DATA_W    = 8,
   parameter int                NUM_SRC   = 6,
   parameter logic [ADDR_W-1:0] EN_ADDR   = 'h06,
   parameter logic [ADDR_W-1:0] REQ_ADDR  = 'h07,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 'h03,
   parameter logic [ADDR_W-1:0] CFG_ADDR  = 'h0D,
   parameter int                STAT_BIT  = 3,
   parameter int                PP_BIT    = 0,
   parameter int                INV_BIT   = 1
) (
   input  logic [ADDR_W-1:0]  rd_addr,
   input  logic [NUM_SRC-1:0] req_q,
   input  logic [NUM_SRC-1:0] en_q,
   input  logic               status,
   input  irqc_pkg::pin_cfg_t cfg_q,
   output logic [DATA_W-1:0]  rd_data
);
   localparam int PAD_W = DATA_W - NUM_SRC;

   always_comb begin
      rd_data = '0;
      if (rd_addr == REQ_ADDR) begin
         rd_data = {{PAD_W{1'b0}}, req_q};
      end else if (rd_addr == EN_ADDR) begin
         rd_data = {{PAD_W{1'b0}}, en_q};
      end else if (rd_addr == STAT_ADDR) begin
         rd_data[STAT_BIT] = status;
      end else if (rd_addr == CFG_ADDR) begin
         rd_data[PP_BIT]  = cfg_q.push_pull;
         rd_data[INV_BIT] = cfg_q.invert;
      end
   end

endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl #(
   parameter int                ADDR_W    = 8,
   parameter int                DATA_W    = 8,
   parameter int                NUM_SRC   = 6,
   parameter int                SEL_BIT   = 7,
   parameter logic [ADDR_W-1:0] EN_ADDR   = 'h06,
   parameter logic [ADDR_W-1:0] REQ_ADDR  = 'h07,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 'h03,
   parameter logic [ADDR_W-1:0] CFG_ADDR  = 'h0D,
   parameter int                STAT_BIT  = 3,
   parameter int                PP_BIT    = 0,
   parameter int                INV_BIT   = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [DATA_W-1:0]  rd_data,
   input  logic [NUM_SRC-1:0] evt_pulse,
   output logic               irq_o,
   output logic               irq_oe
);
   import irqc_pkg::*;

   generate
      if (NUM_SRC > SEL_BIT) begin : g_chk_src
         $error("irq_flag_ctrl: flag bits overlap the set/clear selector");
      end
      if (SEL_BIT >= DATA_W) begin : g_chk_sel
         $error("irq_flag_ctrl: selector bit outside data word");
      end
      if (STAT_BIT >= DATA_W) begin : g_chk_stat
         $error("irq_flag_ctrl: status bit outside data word");
      end
      if (PP_BIT == INV_BIT || PP_BIT >= DATA_W || INV_BIT >= DATA_W) begin : g_chk_cfg
         $error("irq_flag_ctrl: bad pin configuration bit positions");
      end
      if (EN_ADDR == REQ_ADDR || EN_ADDR == STAT_ADDR || EN_ADDR == CFG_ADDR ||
          REQ_ADDR == STAT_ADDR || REQ_ADDR == CFG_ADDR || STAT_ADDR == CFG_ADDR) begin : g_chk_map
         $error("irq_flag_ctrl: register addresses must be distinct");
      end
   endgenerate

   logic [NUM_SRC-1:0] req_q;
   logic [NUM_SRC-1:0] en_q;
   logic               irq_status;
   pin_cfg_t           pin_cfg;
   logic               cfg_pp;
   logic               cfg_inv;
   logic               hit_req, hit_en, hit_cfg;
   logic               wr_data_unused;

   assign hit_req = wr_en && (wr_addr == REQ_ADDR);
   assign hit_en  = wr_en && (wr_addr == EN_ADDR);
   assign hit_cfg = wr_en && (wr_addr == CFG_ADDR);
   assign wr_data_unused = ^wr_data;

   irqc_setclr_bank #(
      .WIDTH     (NUM_SRC),
      .HAS_EVENT (1'b1)
   ) u_req_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hit  (hit_req),
      .wr_sel  (wr_data[SEL_BIT]),
      .wr_mask (wr_data[NUM_SRC-1:0]),
      .evt     (evt_pulse),
      .bits_q  (req_q)
   );

   irqc_setclr_bank #(
      .WIDTH     (NUM_SRC),
      .HAS_EVENT (1'b0)
   ) u_en_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hit  (hit_en),
      .wr_sel  (wr_data[SEL_BIT]),
      .wr_mask (wr_data[NUM_SRC-1:0]),
      .evt     ('0),
      .bits_q  (en_q)
   );

   assign irq_status = |(req_q & en_q);

   irqc_pin_ctrl #(
      .RST_INVERT    (1'b1),
      .RST_PUSH_PULL (1'b0)
   ) u_pin (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (hit_cfg),
      .wr_pp  (wr_data[PP_BIT]),
      .wr_inv (wr_data[INV_BIT]),
      .status (irq_status),
      .cfg_q  (pin_cfg),
      .pin_o  (irq_o),
      .pin_oe (irq_oe)
   );

   assign cfg_pp  = pin_cfg.push_pull;
   assign cfg_inv = pin_cfg.invert;

   irqc_read_mux #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .NUM_SRC   (NUM_SRC),
      .EN_ADDR   (EN_ADDR),
      .REQ_ADDR  (REQ_ADDR),
      .STAT_ADDR (STAT_ADDR),
      .CFG_ADDR  (CFG_ADDR),
      .STAT_BIT  (STAT_BIT),
      .PP_BIT    (PP_BIT),
      .INV_BIT   (INV_BIT)
   ) u_rd (
      .rd_addr (rd_addr),
      .req_q   (req_q),
      .en_q    (en_q),
      .status  (irq_status),
      .cfg_q   (pin_cfg),
      .rd_data (rd_data)
   );

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
   parameter int                ADDR_W   = 8,
   parameter int                NUM_SRC  = 6,
   parameter logic [ADDR_W-1:0] EN_ADDR  = 'h06,
   parameter logic [ADDR_W-1:0] REQ_ADDR = 'h07
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [ADDR_W-1:0]  wr_addr,
   input logic               wr_sel,
   input logic [NUM_SRC-1:0] wr_mask,
   input logic [NUM_SRC-1:0] evt_pulse,
   input logic [NUM_SRC-1:0] req_q,
   input logic [NUM_SRC-1:0] en_q,
   input logic               irq_status,
   input logic               cfg_pp,
   input logic               cfg_inv,
   input logic               irq_o,
   input logic               irq_oe
);
   // R2
   a_r2_set_marked: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == REQ_ADDR && wr_sel)
      |=> ((req_q & $past(wr_mask)) == $past(wr_mask)));

   // R3 and R6
   a_r3_clear_marked: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == REQ_ADDR && !wr_sel)
      |=> ((req_q & $past(wr_mask) & ~$past(evt_pulse)) == '0));

   // R4
   a_r4_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr == EN_ADDR) |=> $stable(en_q));

   // R5 and R6
   a_r5_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_pulse) |=> ((req_q & $past(evt_pulse)) == $past(evt_pulse)));

   // R4, R5
   a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!(wr_en && wr_addr == REQ_ADDR) && evt_pulse == '0) |=> $stable(req_q));

   // R9
   a_r9_push_pull: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_pp |-> (irq_oe && (irq_o == (irq_status ^ cfg_inv))));

   // R10
   a_r10_open_drain: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_pp |-> (!irq_o && (irq_oe == !(irq_status ^ cfg_inv))));

endmodule

bind irq_flag_ctrl irqc_checker #(
   .ADDR_W   (ADDR_W),
   .NUM_SRC  (NUM_SRC),
   .EN_ADDR  (EN_ADDR),
   .REQ_ADDR (REQ_ADDR)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .wr_sel     (wr_data[SEL_BIT]),
   .wr_mask    (wr_data[NUM_SRC-1:0]),
   .evt_pulse  (evt_pulse),
   .req_q      (req_q),
   .en_q       (en_q),
   .irq_status (irq_status),
   .cfg_pp     (cfg_pp),
   .cfg_inv    (cfg_inv),
   .irq_o      (irq_o),
   .irq_oe     (irq_oe)
);

// File: tb/irq_flag_ctrl_bench.sv
`timescale 1ns/1ps
module irq_flag_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic [5:0] evt_pulse = '0;
   logic       irq_o, irq_oe;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   localparam logic [7:0] A_STAT = 8'h03, A_EN = 8'h06, A_REQ = 8'h07, A_CFG = 8'h0D;

   always #2.5 clk = ~clk;

   irq_flag_ctrl u_irq_flag_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .evt_pulse(evt_pulse),
      .irq_o(irq_o), .irq_oe(irq_oe)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic write_evt(input logic [7:0] a, input logic [7:0] d, input logic [5:0] e);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d; evt_pulse = e;
      @(negedge clk);
      wr_en = 1'b0; evt_pulse = '0;
   endtask

   task automatic write(input logic [7:0] a, input logic [7:0] d);
      write_evt(a, d, 6'h00);
   endtask

   task automatic read_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
      rd_addr = a;
      #1;
      check(tag, rd_data, exp);
   endtask

   task automatic pin_chk(input string tag, input logic exp_o, input logic exp_oe);
      #1;
      check(tag, {6'b0, irq_o, irq_oe}, {6'b0, exp_o, exp_oe});
   endtask

   task automatic t_reset;
      read_chk("R1 request after reset", A_REQ, 8'h00);
      read_chk("R1 enable after reset", A_EN, 8'h00);
      read_chk("R1 status after reset", A_STAT, 8'h00);
      read_chk("R8 config reset value", A_CFG, 8'h02);
      pin_chk("R1 pin high impedance", 1'b0, 1'b0);
   endtask

   task automatic t_set_clear;
      write(A_REQ, 8'h81);
      read_chk("R2 81h sets bit 0 only", A_REQ, 8'h01);
      write(A_REQ, 8'hBE);
      read_chk("R2 set all, bit 7 reads 0", A_REQ, 8'h3F);
      write(A_REQ, 8'h3F);
      read_chk("R3 3Fh clears all", A_REQ, 8'h00);
      write(A_REQ, 8'hC4);
      read_chk("R4 bit 6 ignored on request", A_REQ, 8'h04);
      write(A_REQ, 8'h02);
      read_chk("R3 clear leaves unmarked bits", A_REQ, 8'h04);
      write(A_REQ, 8'h04);
      read_chk("R3 clear marked bit", A_REQ, 8'h00);
   endtask

   task automatic t_enable;
      write(A_EN, 8'hDA);
      read_chk("R4 enable set, bit 6 ignored", A_EN, 8'h1A);
      write(A_EN, 8'h08);
      read_chk("R4 enable clear", A_EN, 8'h12);
      write(A_REQ, 8'h90);
      write(8'h05, 8'hFF);
      write(8'h05, 8'h3F);
      read_chk("R4 stray write keeps request", A_REQ, 8'h10);
      read_chk("R4 stray write keeps enable", A_EN, 8'h12);
      write(A_EN, 8'h3F);
      write(A_REQ, 8'h3F);
   endtask

   task automatic t_events;
      write(A_EN, 8'h84);
      @(negedge clk); evt_pulse = 6'h21;
      @(negedge clk); evt_pulse = 6'h00;
      read_chk("R5 events raise flags", A_REQ, 8'h21);
      read_chk("R5 events leave enables", A_EN, 8'h04);
      @(negedge clk); evt_pulse = 6'h02;
      @(negedge clk); evt_pulse = 6'h00;
      read_chk("R5 second event accumulates", A_REQ, 8'h23);
   endtask

   task automatic t_priority;
      write(A_REQ, 8'hBF);
      write_evt(A_REQ, 8'h3F, 6'h08);
      read_chk("R6 event beats clear", A_REQ, 8'h08);
      write_evt(A_REQ, 8'h3F, 6'h00);
      read_chk("R3 clear without event", A_REQ, 8'h00);
   endtask

   task automatic t_status;
      write(A_EN, 8'h3F);
      write(A_EN, 8'h88);
      write(A_REQ, 8'h90);
      read_chk("R7 pending but not enabled", A_STAT, 8'h00);
      write(A_REQ, 8'h88);
      read_chk("R7 pending and enabled", A_STAT, 8'h08);
      write(A_EN, 8'h08);
      read_chk("R7 enable removed", A_STAT, 8'h00);
      write(A_EN, 8'h90);
      read_chk("R7 other enabled source", A_STAT, 8'h08);
      write(A_EN, 8'h3F);
      write(A_REQ, 8'h3F);
   endtask

   // status is made 1 by enabling bit 3 with flag 3 set, 0 by clearing the enable
   task automatic set_status(input logic s);
      write(A_EN, s ? 8'h88 : 8'h08);
   endtask

   task automatic t_pin;
      write(A_REQ, 8'h88);
      set_status(1'b0);
      pin_chk("R10 reset mode, status 0", 1'b0, 1'b0);
      set_status(1'b1);
      pin_chk("R10 inverted open-drain, status 1", 1'b0, 1'b1);
      write(A_CFG, 8'h01);
      read_chk("R8 config push-pull", A_CFG, 8'h01);
      pin_chk("R9 push-pull, status 1", 1'b1, 1'b1);
      set_status(1'b0);
      pin_chk("R9 push-pull, status 0", 1'b0, 1'b1);
      write(A_CFG, 8'hFF);
      read_chk("R8 config upper bits read 0", A_CFG, 8'h03);
      pin_chk("R9 inverted push-pull, status 0", 1'b1, 1'b1);
      set_status(1'b1);
      pin_chk("R9 inverted push-pull, status 1", 1'b0, 1'b1);
      write(A_CFG, 8'h00);
      pin_chk("R10 open-drain, status 1", 1'b0, 1'b0);
      set_status(1'b0);
      pin_chk("R10 open-drain, status 0", 1'b0, 1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_set_clear();
      t_enable();
      t_events();
      t_priority();
      t_status();
      t_pin();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule